// File: doc/BRIEF.md
# Exception Return Unit

This block carries out the return-from-exception step of a processor core that has two privilege levels (0 and 1) and two execution states (a 64-bit state and a 32-bit state). When a return is requested, the block receives the saved status word, the return address, the current status word, the live stack pointer and the two banked stack pointers, one per level. First it writes the live stack pointer back into the bank that the current stack-select bit names. It then decodes the saved status and picks one of three outcomes: a legal return to 64-bit state, a legal return to 32-bit state at level 0, or an illegal return.

One clock after the request strobe, the block presents the new status word, the new program counter and the new live stack pointer. In the same cycle it presents the stack-bank write-back, a strobe that resets the exclusive monitor to its all-ones address, and an illegal-outcome flag.

On an illegal return, only the condition flags and interrupt masks come from the saved word, and the illegal-state bit is set. The level, the execution state and the stack choice do not change.

Status word layout used throughout: bit 0 is the stack select, bit 1 is reserved, bits [3:2] are the level, bit 4 is the execution state (1 = 32-bit), bits [9:6] are the interrupt masks, bit 20 is the illegal-state bit, and bits [31:28] are the condition flags.

Top module: `er_return_unit`

## Requirements
- R1: Every result cycle raises `bank_we`. `bank_sel` equals bit 0 of the current status and `bank_wdata` equals the live stack pointer, both sampled at the request.
- R2: Every result cycle raises `excl_clr` for exactly that cycle.
- R3: A request at one clock edge produces `out_valid` high exactly one cycle later. With no request, `out_valid` stays low.
- R4: If saved bit 4 is 1, the return is legal and goes to 32-bit state. The new status is the saved word, the PC is the return address with bit 0 cleared, and the stack pointer is the level-0 bank value.
- R5: If saved bit 4 is 0 and the level field [3:2] is greater than 1, the return is illegal.
- R6: If saved bit 4 is 0 and saved bit 1 is set, the return is illegal.
- R7: If saved bit 4 is 0, the level is 0 and saved bit 0 is set, the return is illegal.
- R8: On a legal 64-bit return, the new status is the saved word, the PC is the return address unchanged, and the stack pointer is the bank of the target level. `out_illegal` is low.
- R9: If the bank the result reads is the same bank being saved (target bank equal to current bit 0), the new stack pointer is the live stack pointer, not the stale bank input.
- R10: On an illegal return, `out_illegal` is high. Status bits [31:28] and [9:6] come from the saved word, bit 20 is set, all other bits keep the current status, the PC is the return address, and the stack pointer is unchanged.
- R11: While reset is high, and in the first cycle after it, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ret_valid | input | 1 | Return request strobe |
| saved_status | input | 32 | Saved status word |
| ret_addr | input | XLEN | Return address |
| cur_status | input | 32 | Current status word |
| live_sp | input | XLEN | Live stack pointer |
| bank_sp0 | input | XLEN | Level-0 banked stack pointer |
| bank_sp1 | input | XLEN | Level-1 banked stack pointer |
| out_valid | output | 1 | Result valid |
| out_illegal | output | 1 | Illegal-return outcome |
| out_status | output | 32 | New status word |
| out_pc | output | XLEN | New program counter |
| out_sp | output | XLEN | New live stack pointer |
| bank_we | output | 1 | Stack-bank write-back enable |
| bank_sel | output | 1 | Bank written (0 or 1) |
| bank_wdata | output | XLEN | Value written to the bank |
| excl_clr | output | 1 | Exclusive-monitor clear strobe |

## Verification
The assertions assume that `ret_valid` is low while reset is high. They also assume every input is stable around the clock edge where a request is sampled, because each result is compared against `$past` of those inputs. The stimulus drives inputs only on falling edges and holds `ret_valid` low throughout reset. It sends requests both back to back and with gaps, so the one-cycle latency is checked in both spacings. Saved words are built to land in each outcome class, including every forwarding combination of target bank and current stack select.

// File: rtl/er_pkg.sv
package er_pkg;
    localparam int ST_W      = 32;
    localparam int B_SPSEL   = 0;
    localparam int B_MRES    = 1;
    localparam int B_LVL_LO  = 2;
    localparam int B_EXEC    = 4;
    localparam int B_MASK_LO = 6;
    localparam int B_MASK_HI = 9;
    localparam int B_ILL     = 20;
    localparam int B_FLG_LO  = 28;
    localparam int B_FLG_HI  = 31;

    typedef enum logic [1:0] {
        RK_WIDE   = 2'd0,
        RK_NARROW = 2'd1,
        RK_BAD    = 2'd2
    } ret_kind_e;

    typedef struct packed {
        ret_kind_e kind;
        logic      tgt_bank;
    } ret_dec_t;

    function automatic ret_dec_t classify(input logic [ST_W-1:0] sv);
        ret_dec_t d;
        logic [1:0] lvl;
        lvl = sv[B_LVL_LO+1:B_LVL_LO];
        d.tgt_bank = 1'b0;
        if (sv[B_EXEC]) begin
            d.kind = RK_NARROW;
        end else if (lvl > 2'd1 || sv[B_MRES] || (lvl == 2'd0 && sv[B_SPSEL])) begin
            d.kind = RK_BAD;
        end else begin
            d.kind     = RK_WIDE;
            d.tgt_bank = lvl[0];
        end
        return d;
    endfunction

    function automatic logic [ST_W-1:0] keep_mask();
        logic [ST_W-1:0] m;
        m = '1;
        m[B_FLG_HI:B_FLG_LO]   = '0;
        m[B_MASK_HI:B_MASK_LO] = '0;
        return m;
    endfunction
endpackage

// File: rtl/er_decode.sv
module er_decode
    import er_pkg::*;
(
    input  logic [ST_W-1:0] saved_status,
    output ret_dec_t        dec
);
    always_comb dec = classify(saved_status);
endmodule

// File: rtl/er_sp_select.sv
module er_sp_select
    import er_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            cur_sel,
    input  logic [XLEN-1:0] live_sp,
    input  logic [XLEN-1:0] bank_sp0,
    input  logic [XLEN-1:0] bank_sp1,
    input  ret_dec_t        dec,
    output logic [XLEN-1:0] sp_next
);
    localparam int NUM_LVL = 2;

    logic [NUM_LVL-1:0][XLEN-1:0] raw;
    logic [NUM_LVL-1:0][XLEN-1:0] fwd;

    assign raw[0] = bank_sp0;
    assign raw[1] = bank_sp1;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_fwd
        assign fwd[g] = (cur_sel == 1'(g)) ? live_sp : raw[g];
    end

    always_comb begin
        unique case (dec.kind)
            RK_WIDE:   sp_next = fwd[dec.tgt_bank];
            RK_NARROW: sp_next = fwd[0];
            default:   sp_next = live_sp;
        endcase
    end
endmodule

// File: rtl/er_result_mux.sv
module er_result_mux
    import er_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  ret_dec_t        dec,
    input  logic [ST_W-1:0] saved_status,
    input  logic [ST_W-1:0] cur_status,
    input  logic [XLEN-1:0] ret_addr,
    output logic [ST_W-1:0] status_next,
    output logic [XLEN-1:0] pc_next
);
    localparam logic [ST_W-1:0] KEEP = keep_mask();

    always_comb begin
        status_next = saved_status;
        pc_next     = ret_addr;
        unique case (dec.kind)
            RK_NARROW: pc_next[0] = 1'b0;
            RK_BAD: begin
                status_next        = (cur_status & KEEP) | (saved_status & ~KEEP);
                status_next[B_ILL] = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/er_return_unit.sv
module er_return_unit
    import er_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ret_valid,
    input  logic [31:0]     saved_status,
    input  logic [XLEN-1:0] ret_addr,
    input  logic [31:0]     cur_status,
    input  logic [XLEN-1:0] live_sp,
    input  logic [XLEN-1:0] bank_sp0,
    input  logic [XLEN-1:0] bank_sp1,
    output logic            out_valid,
    output logic            out_illegal,
    output logic [31:0]     out_status,
    output logic [XLEN-1:0] out_pc,
    output logic [XLEN-1:0] out_sp,
    output logic            bank_we,
    output logic            bank_sel,
    output logic [XLEN-1:0] bank_wdata,
    output logic            excl_clr
);
    ret_dec_t        dec;
    logic [ST_W-1:0] status_n;
    logic [XLEN-1:0] pc_n;
    logic [XLEN-1:0] sp_n;

    er_decode u_dec (
        .saved_status(saved_status),
        .dec         (dec)
    );

    er_sp_select #(.XLEN(XLEN)) u_sp (
        .cur_sel (cur_status[B_SPSEL]),
        .live_sp (live_sp),
        .bank_sp0(bank_sp0),
        .bank_sp1(bank_sp1),
        .dec     (dec),
        .sp_next (sp_n)
    );

    er_result_mux #(.XLEN(XLEN)) u_mux (
        .dec         (dec),
        .saved_status(saved_status),
        .cur_status  (cur_status),
        .ret_addr    (ret_addr),
        .status_next (status_n),
        .pc_next     (pc_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_status  <= '0;
            out_pc      <= '0;
            out_sp      <= '0;
            bank_we     <= 1'b0;
            bank_sel    <= 1'b0;
            bank_wdata  <= '0;
            excl_clr    <= 1'b0;
        end else begin
            out_valid <= ret_valid;
            bank_we   <= ret_valid;
            excl_clr  <= ret_valid;
            if (ret_valid) begin
                out_illegal <= (dec.kind == RK_BAD);
                out_status  <= status_n;
                out_pc      <= pc_n;
                out_sp      <= sp_n;
                bank_sel    <= cur_status[B_SPSEL];
                bank_wdata  <= live_sp;
            end else begin
                out_illegal <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/er_return_checker.sv
module er_return_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            ret_valid,
    input logic [31:0]     saved_status,
    input logic [XLEN-1:0] ret_addr,
    input logic [31:0]     cur_status,
    input logic [XLEN-1:0] live_sp,
    input logic            out_valid,
    input logic            out_illegal,
    input logic [31:0]     out_status,
    input logic [XLEN-1:0] out_pc,
    input logic [XLEN-1:0] out_sp,
    input logic            bank_we,
    input logic            bank_sel,
    input logic [XLEN-1:0] bank_wdata,
    input logic            excl_clr
);
    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(ret_valid));
    assert_issue_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(ret_valid) && !$past(rst)) |-> out_valid);
    assert_excl_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(ret_valid) && !$past(rst)) |-> excl_clr);
    assert_bank_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (bank_we && bank_sel == $past(cur_status[0])
                       && bank_wdata == $past(live_sp)));
    assert_narrow_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(saved_status[4])) |-> (!out_illegal && !out_pc[0]));
    assert_level_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(saved_status[4]) && $past(saved_status[3])) |-> out_illegal);
    assert_resv_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(saved_status[4]) && $past(saved_status[1])) |-> out_illegal);
    assert_l0sel_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(saved_status[4:2]) == 3'b000 && $past(saved_status[0])) |-> out_illegal);
    assert_fwd_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_illegal && !$past(saved_status[4])
         && $past(saved_status[2]) == $past(cur_status[0])) |-> out_sp == $past(live_sp));
    assert_bad_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (out_status[20] && out_status[4:0] == $past(cur_status[4:0])
                                        && out_pc == $past(ret_addr) && out_sp == $past(live_sp)));
endmodule

bind er_return_unit er_return_checker #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst(rst), .ret_valid(ret_valid), .saved_status(saved_status),
    .ret_addr(ret_addr), .cur_status(cur_status), .live_sp(live_sp),
    .out_valid(out_valid), .out_illegal(out_illegal), .out_status(out_status),
    .out_pc(out_pc), .out_sp(out_sp), .bank_we(bank_we), .bank_sel(bank_sel),
    .bank_wdata(bank_wdata), .excl_clr(excl_clr)
);

// File: tb/tb_er_return_unit.sv
module tb_er_return_unit;
    localparam int  XLEN = 64;
    localparam time TCLK = 10ns;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ret_valid = 1'b0;
    logic [31:0]     saved_status = '0;
    logic [XLEN-1:0] ret_addr = '0;
    logic [31:0]     cur_status = '0;
    logic [XLEN-1:0] live_sp = '0;
    logic [XLEN-1:0] bank_sp0 = '0;
    logic [XLEN-1:0] bank_sp1 = '0;
    logic            out_valid, out_illegal, bank_we, bank_sel, excl_clr;
    logic [31:0]     out_status;
    logic [XLEN-1:0] out_pc, out_sp, bank_wdata;

    er_return_unit #(.XLEN(XLEN)) dut (.*);

    always #(TCLK/2) clk = ~clk;

    typedef struct {
        string           req;
        logic            ill;
        logic [31:0]     st;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] sp;
        logic            sel;
        logic [XLEN-1:0] wd;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 0;

    task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic send(string req, logic [31:0] sv, logic [XLEN-1:0] ra,
                        logic [31:0] cs, logic [XLEN-1:0] lsp,
                        logic [XLEN-1:0] b0, logic [XLEN-1:0] b1);
        exp_t e;
        logic [1:0] lvl;
        logic [XLEN-1:0] f0, f1;
        @(negedge clk);
        ret_valid = 1'b1; saved_status = sv; ret_addr = ra;
        cur_status = cs; live_sp = lsp; bank_sp0 = b0; bank_sp1 = b1;
        f0 = cs[0] ? b0 : lsp;
        f1 = cs[0] ? lsp : b1;
        lvl = sv[3:2];
        e.req = req; e.sel = cs[0]; e.wd = lsp; e.pc = ra;
        if (sv[4]) begin
            e.ill = 0; e.st = sv; e.pc[0] = 1'b0; e.sp = f0;
        end else if (lvl > 1 || sv[1] || (lvl == 0 && sv[0])) begin
            e.ill = 1; e.sp = lsp;
            e.st = cs; e.st[31:28] = sv[31:28]; e.st[9:6] = sv[9:6]; e.st[20] = 1'b1;
        end else begin
            e.ill = 0; e.st = sv; e.sp = lvl[0] ? f1 : f0;
        end
        @(posedge clk);
        #1 q.push_back(e);
    endtask

    task automatic idle(int n);
        @(negedge clk);
        ret_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    check("R3 unexpected valid", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check({e.req, " illegal"}, XLEN'(out_illegal), XLEN'(e.ill));
                    check({e.req, " status"}, XLEN'(out_status), XLEN'(e.st));
                    check({e.req, " pc"}, out_pc, e.pc);
                    check({e.req, " sp"}, out_sp, e.sp);
                    check("R1 bank_we/sel", {bank_we, bank_sel}, {1'b1, e.sel});
                    check("R1 bank_wdata", bank_wdata, e.wd);
                    check("R2 excl_clr", XLEN'(excl_clr), 1);
                end
            end else begin
                check("R3 valid missing", XLEN'(q.size()), 0);
                check("R2 excl_clr idle", XLEN'(excl_clr), 0);
            end
        end
    end

    initial begin
        #(TCLK * 50000);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset valid", XLEN'(out_valid), 0);
        check("R11 reset status", XLEN'(out_status), 0);
        check("R11 reset pc/sp", out_pc | out_sp | bank_wdata, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R11 post-reset", XLEN'({out_valid, bank_we, excl_clr, out_illegal}), 0);
        // legal 64-bit, no forwarding
        send("R8 to L0",   32'hA000_03C0, 64'h1000, 32'h0000_0005, 64'hAAAA, 64'h0B00, 64'h0B11);
        send("R8 to L1h",  32'h5000_0005, 64'h2004, 32'h0000_0004, 64'hBBBB, 64'h0C00, 64'h0C11);
        idle(2);
        // forwarding
        send("R9 L1h from sel1", 32'h0000_0005, 64'h3000, 32'h0000_0005, 64'hCCCC, 64'h0D00, 64'h0D11);
        send("R9 L0 from sel0",  32'h0000_0000, 64'h3008, 32'h0000_0004, 64'hDDDD, 64'h0E00, 64'h0E11);
        // 32-bit returns
        send("R4 odd addr",  32'h8000_0010, 64'h4001, 32'h0000_0005, 64'hEEEE, 64'h0F00, 64'h0F11);
        send("R4 fwd bank0", 32'h0000_001F, 64'h4003, 32'h0000_0004, 64'h1234, 64'h1000, 64'h1011);
        idle(1);
        // illegal
        send("R5 level2",  32'hF000_0388, 64'h5001, 32'h0FF0_0C35, 64'h5555, 64'h1100, 64'h1111);
        send("R5 level3",  32'h1000_004C, 64'h5008, 32'h0000_0004, 64'h6666, 64'h1200, 64'h1211);
        send("R6 resv bit", 32'h6000_0006, 64'h5010, 32'h0000_0005, 64'h7777, 64'h1300, 64'h1311);
        send("R7 L0 sel1", 32'h9000_0241, 64'h5018, 32'hFFEF_FC3D, 64'h8888, 64'h1400, 64'h1411);
        send("R10 merge",  32'h3000_00C2, 64'h5020, 32'hC00F_0305, 64'h9999, 64'h1500, 64'h1511);
        idle(3);
        check("R3 queue drained", XLEN'(q.size()), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule